// File: doc/BRIEF.md
# Accelerometer Self-Test Sequencer

This block runs the electromechanical self-test of a three-axis accelerometer with no processor involved. After a start pulse it issues a configuration write that puts the sensor in its normal measuring mode with self-test off. It waits for the output to settle and then averages a window of samples on each axis. Next it writes the configuration that switches self-test on, waits again and averages a second window. It then writes the self-test-off configuration again.

Once that last write has been accepted, the block subtracts the first average from the second on each axis. It checks each difference against a signed window of limits supplied from outside. A one-cycle strobe marks the moment the three differences and the three pass bits become valid.

Configuration writes leave through a simple request/acknowledge port that a bus engine serves. Samples arrive as a stream qualified by a valid bit. An abort input cuts the sequence short, but the block always leaves the sensor with self-test switched off.

Top module: `accel_selftest_seq`

## Requirements
- R1: After reset the block is idle. wr_req_o, done_o and busy_o are 0, pass_o is 3'b000 and all three delta outputs are 0.
- R2: A start_i pulse while idle raises busy_o in the next cycle. The first write request then carries address 0x31 and data 0x0B. A request holds wr_req_o, wr_addr_o and wr_data_o unchanged until the cycle in which wr_ack_i is high, and that cycle completes the transfer.
- R3: After each self-test-changing write completes (the first write and the self-test-on write), the block ignores samples for SETTLE_CYC cycles before it starts accumulating.
- R4: Each window accepts exactly N_AVG samples, counting only cycles with smp_valid_i high. The average is the signed sum divided by N_AVG, truncated toward zero. Samples outside a window have no effect.
- R5: After the first window the block writes data 0x8B to address 0x31 (self-test on), then waits as in R3 and runs the second window.
- R6: After the second window the block writes data 0x0B to address 0x31 (self-test off). No write ever uses another address or another data value.
- R7: Each delta output equals the self-test-on average minus the self-test-off average for its axis, as a signed value SMP_W+1 bits wide.
- R8: pass_o bit 0 refers to X, bit 1 to Y and bit 2 to Z. A bit is 1 exactly when lim_min <= delta <= lim_max for that axis, compared as signed values, with both bounds inclusive.
- R9: done_o is high for exactly one cycle, two cycles after the cycle that completes the final write. The deltas and pass_o change only in that cycle and then hold until the next run produces results.
- R10: If abort_i is high in any busy cycle before the final write completes, the sequence ends with a completed write of 0x0B to 0x31 and returns to idle. No done pulse follows, and the earlier deltas and pass_o stay unchanged. abort_i has no effect while the block is idle.
- R11: start_i is ignored while busy. A run always issues exactly three writes, in the order 0x0B, 0x8B, 0x0B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a self-test run when idle |
| abort_i | input | 1 | Cuts the run short; self-test is still turned off |
| wr_req_o | output | 1 | Configuration write request |
| wr_addr_o | output | 8 | Register address of the write |
| wr_data_o | output | 8 | Data of the write |
| wr_ack_i | input | 1 | Write accepted in this cycle |
| smp_valid_i | input | 1 | The sample inputs hold a new sample |
| smp_x_i | input | SMP_W | X sample, signed |
| smp_y_i | input | SMP_W | Y sample, signed |
| smp_z_i | input | SMP_W | Z sample, signed |
| lim_min_x_i | input | SMP_W+1 | Lowest passing X delta, signed |
| lim_max_x_i | input | SMP_W+1 | Highest passing X delta, signed |
| lim_min_y_i | input | SMP_W+1 | Lowest passing Y delta, signed |
| lim_max_y_i | input | SMP_W+1 | Highest passing Y delta, signed |
| lim_min_z_i | input | SMP_W+1 | Lowest passing Z delta, signed |
| lim_max_z_i | input | SMP_W+1 | Highest passing Z delta, signed |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle strobe: results are valid |
| pass_o | output | 3 | Per-axis pass bits {Z,Y,X} |
| delta_x_o | output | SMP_W+1 | X self-test delta, signed |
| delta_y_o | output | SMP_W+1 | Y self-test delta, signed |
| delta_z_o | output | SMP_W+1 | Z self-test delta, signed |

## Verification
Runs use random noisy samples around negative as well as positive baselines. Negative baselines give negative sums, which show whether division truncates toward zero or floors. Large junk samples arrive during the settle waits and right after the second window. Valid gaps fall inside the windows. Together these separate the correct sample count from an off-by-one count or a window boundary in the wrong place. The limits are set randomly around the expected delta and also exactly at it, one above it and one below it, which shows whether both bounds are inclusive and signed. Aborts during the first window and during the second settle wait show whether the closing write sends self-test off rather than on. A start pulse in mid-run and an abort while idle must leave the write sequence and the results untouched.

// File: rtl/accel_st_pkg.sv
package accel_st_pkg;
  localparam logic [7:0] CFG_ADDR   = 8'h31;
  localparam logic [7:0] CFG_ST_OFF = 8'h0B;
  localparam logic [7:0] CFG_ST_ON  = 8'h8B;

  typedef enum logic [3:0] {
    S_IDLE, S_WR_BASE, S_WAIT_OFF, S_ACC_OFF, S_LATCH,
    S_WR_ON, S_WAIT_ON, S_ACC_ON, S_WR_OFF, S_CALC
  } seq_state_e;
endpackage

// File: rtl/accel_st_ctrl.sv
module accel_st_ctrl
  import accel_st_pkg::*;
#(
  parameter int N_AVG      = 100,
  parameter int SETTLE_CYC = 55000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic       wr_ack_i,
  input  logic       smp_valid_i,
  output logic       wr_req_o,
  output logic [7:0] wr_data_o,
  output logic       busy_o,
  output logic       clr_o,
  output logic       acc_o,
  output logic       latch_o,
  output logic       calc_o
);
  localparam int CMAX = (N_AVG > SETTLE_CYC) ? N_AVG : SETTLE_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] AVG_LAST    = CW'(N_AVG - 1);

  seq_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            abort_q, abort_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    abort_d = abort_q | (abort_i && state_q != S_IDLE && state_q != S_CALC);
    unique case (state_q)
      S_IDLE: begin
        abort_d = 1'b0;
        if (start_i) state_d = S_WR_BASE;
      end
      S_WR_BASE, S_WR_ON: if (wr_ack_i) begin
        cnt_d   = '0;
        state_d = abort_d ? S_WR_OFF : (state_q == S_WR_BASE ? S_WAIT_OFF : S_WAIT_ON);
      end
      S_WAIT_OFF, S_WAIT_ON: begin
        if (abort_d) state_d = S_WR_OFF;
        else if (cnt_q == SETTLE_LAST) begin
          cnt_d   = '0;
          state_d = (state_q == S_WAIT_OFF) ? S_ACC_OFF : S_ACC_ON;
        end else cnt_d = cnt_q + 1'b1;
      end
      S_ACC_OFF, S_ACC_ON: begin
        if (abort_d) state_d = S_WR_OFF;
        else if (smp_valid_i) begin
          if (cnt_q == AVG_LAST) state_d = (state_q == S_ACC_OFF) ? S_LATCH : S_WR_OFF;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      S_LATCH:  state_d = abort_d ? S_WR_OFF : S_WR_ON;
      S_WR_OFF: if (wr_ack_i) state_d = abort_d ? S_IDLE : S_CALC;
      S_CALC:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      abort_q <= abort_d;
    end
  end

  assign wr_req_o  = (state_q == S_WR_BASE) || (state_q == S_WR_ON) || (state_q == S_WR_OFF);
  assign wr_data_o = (state_q == S_WR_ON) ? CFG_ST_ON : CFG_ST_OFF;
  assign busy_o    = (state_q != S_IDLE);
  assign clr_o     = (state_q == S_WR_BASE) || (state_q == S_WR_ON);
  assign acc_o     = smp_valid_i && ((state_q == S_ACC_OFF) || (state_q == S_ACC_ON));
  assign latch_o   = (state_q == S_LATCH);
  assign calc_o    = (state_q == S_CALC);
endmodule

// File: rtl/accel_st_axis.sv
module accel_st_axis #(
  parameter int SMP_W = 16,
  parameter int N_AVG = 100,
  localparam int DW   = SMP_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    acc_i,
  input  logic                    latch_i,
  input  logic                    calc_i,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic signed [DW-1:0]    lim_min_i,
  input  logic signed [DW-1:0]    lim_max_i,
  output logic signed [DW-1:0]    delta_o,
  output logic                    pass_o
);
  localparam int SUM_W = SMP_W + $clog2(N_AVG) + 1;
  localparam logic signed [SUM_W-1:0] N_S = SUM_W'(N_AVG);

  logic signed [SUM_W-1:0] sum_q;
  logic signed [SMP_W-1:0] base_q, avg_w;
  logic signed [DW-1:0]    delta_w;

  // signed division truncates toward zero
  assign avg_w   = SMP_W'(sum_q / N_S);
  assign delta_w = DW'(avg_w) - DW'(base_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= '0;
      base_q  <= '0;
      delta_o <= '0;
      pass_o  <= 1'b0;
    end else begin
      if (clr_i)      sum_q <= '0;
      else if (acc_i) sum_q <= sum_q + SUM_W'(smp_i);
      if (latch_i) base_q <= avg_w;
      if (calc_i) begin
        delta_o <= delta_w;
        pass_o  <= (delta_w >= lim_min_i) && (delta_w <= lim_max_i);
      end
    end
  end
endmodule

// File: rtl/accel_selftest_seq.sv
module accel_selftest_seq
  import accel_st_pkg::*;
#(
  parameter int SMP_W      = 16,
  parameter int N_AVG      = 100,
  parameter int SETTLE_CYC = 55000,
  localparam int DW        = SMP_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    abort_i,
  output logic                    wr_req_o,
  output logic [7:0]              wr_addr_o,
  output logic [7:0]              wr_data_o,
  input  logic                    wr_ack_i,
  input  logic                    smp_valid_i,
  input  logic signed [SMP_W-1:0] smp_x_i,
  input  logic signed [SMP_W-1:0] smp_y_i,
  input  logic signed [SMP_W-1:0] smp_z_i,
  input  logic signed [DW-1:0]    lim_min_x_i,
  input  logic signed [DW-1:0]    lim_max_x_i,
  input  logic signed [DW-1:0]    lim_min_y_i,
  input  logic signed [DW-1:0]    lim_max_y_i,
  input  logic signed [DW-1:0]    lim_min_z_i,
  input  logic signed [DW-1:0]    lim_max_z_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [2:0]              pass_o,
  output logic signed [DW-1:0]    delta_x_o,
  output logic signed [DW-1:0]    delta_y_o,
  output logic signed [DW-1:0]    delta_z_o
);
  localparam int AXES = 3;

  logic clr, acc, latch, calc;
  logic signed [SMP_W-1:0] smp_a   [AXES];
  logic signed [DW-1:0]    min_a   [AXES];
  logic signed [DW-1:0]    max_a   [AXES];
  logic signed [DW-1:0]    delta_a [AXES];

  assign smp_a = '{smp_x_i, smp_y_i, smp_z_i};
  assign min_a = '{lim_min_x_i, lim_min_y_i, lim_min_z_i};
  assign max_a = '{lim_max_x_i, lim_max_y_i, lim_max_z_i};

  accel_st_ctrl #(.N_AVG(N_AVG), .SETTLE_CYC(SETTLE_CYC)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .abort_i, .wr_ack_i, .smp_valid_i,
    .wr_req_o, .wr_data_o, .busy_o,
    .clr_o(clr), .acc_o(acc), .latch_o(latch), .calc_o(calc)
  );

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    accel_st_axis #(.SMP_W(SMP_W), .N_AVG(N_AVG)) i_axis (
      .clk_i, .rst_ni,
      .clr_i(clr), .acc_i(acc), .latch_i(latch), .calc_i(calc),
      .smp_i(smp_a[a]), .lim_min_i(min_a[a]), .lim_max_i(max_a[a]),
      .delta_o(delta_a[a]), .pass_o(pass_o[a])
    );
  end

  assign delta_x_o = delta_a[0];
  assign delta_y_o = delta_a[1];
  assign delta_z_o = delta_a[2];
  assign wr_addr_o = CFG_ADDR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= calc;
  end
endmodule

// File: rtl/accel_selftest_seq_chk.sv
module accel_selftest_seq_chk #(
  parameter int DW = 17
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          wr_req_o,
  input logic          wr_ack_i,
  input logic [7:0]    wr_addr_o,
  input logic [7:0]    wr_data_o,
  input logic          done_o,
  input logic          busy_o,
  input logic [2:0]    pass_o,
  input logic [DW-1:0] delta_x_o
);
  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));
  // R6
  wr_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> wr_addr_o == 8'h31 && (wr_data_o == 8'h0B || wr_data_o == 8'h8B));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_after_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wr_req_o && wr_ack_i && wr_data_o == 8'h0B, 2));
  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({pass_o, delta_x_o}) |-> done_o);
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wr_req_o);
endmodule

bind accel_selftest_seq accel_selftest_seq_chk #(.DW(SMP_W + 1)) i_chk (.*);

// File: tb/test_accel_selftest_seq.sv
module test_accel_selftest_seq;
  localparam int SMP_W = 16, N_AVG = 100, SETTLE = 40, DW = SMP_W + 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, abort_i = 1'b0, wr_ack_i = 1'b0, smp_valid_i = 1'b0;
  logic wr_req_o, busy_o, done_o;
  logic [7:0] wr_addr_o, wr_data_o;
  logic [2:0] pass_o;
  logic signed [SMP_W-1:0] smp_x_i = '0, smp_y_i = '0, smp_z_i = '0;
  logic signed [DW-1:0] lim_min_x_i = '0, lim_max_x_i = '0, lim_min_y_i = '0;
  logic signed [DW-1:0] lim_max_y_i = '0, lim_min_z_i = '0, lim_max_z_i = '0;
  logic signed [DW-1:0] delta_x_o, delta_y_o, delta_z_o;

  accel_selftest_seq #(.SMP_W(SMP_W), .N_AVG(N_AVG), .SETTLE_CYC(SETTLE)) i_accel_selftest_seq (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int wr_n = 0, done_n = 0, ack_wait = 0;
  logic [7:0] wr_a [64];
  logic [7:0] wr_d [64];
  logic done_prev = 1'b0;
  int exp_d [3];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i)
    if (wr_req_o && wr_ack_i && wr_n < 64) begin
      wr_a[wr_n] <= wr_addr_o;
      wr_d[wr_n] <= wr_data_o;
      wr_n <= wr_n + 1;
    end

  always @(negedge clk_i) begin
    if (wr_ack_i) wr_ack_i = 1'b0;
    else if (wr_req_o) begin
      if (ack_wait == 0) begin
        wr_ack_i = 1'b1;
        ack_wait = int'($urandom_range(0, 4));
      end else ack_wait--;
    end
    if (done_o) begin
      done_n++;
      if (done_prev) chk(0, "R9 done width", 2, 1);
    end
    done_prev = done_o;
  end

  task automatic wait_wr(input int k);
    while (wr_n < k) @(negedge clk_i);
  endtask

  task automatic junk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      smp_valid_i = 1'b1;
      smp_x_i = 16'sh7000; smp_y_i = -16'sh7000; smp_z_i = 16'sh5555;
    end
    @(negedge clk_i) smp_valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic win(input int b0, input int b1, input int b2, output int av [3]);
    int s [3];
    int k = 0;
    int b [3];
    b = '{b0, b1, b2};
    s = '{0, 0, 0};
    while (k < N_AVG) begin
      @(negedge clk_i);
      if ($urandom_range(0, 3) == 0) smp_valid_i = 1'b0;
      else begin
        int v [3];
        for (int a = 0; a < 3; a++) begin
          v[a] = b[a] + int'($urandom_range(0, 64)) - 32;
          s[a] += v[a];
        end
        smp_x_i = 16'(v[0]); smp_y_i = 16'(v[1]); smp_z_i = 16'(v[2]);
        smp_valid_i = 1'b1;
        k++;
      end
    end
    @(negedge clk_i) smp_valid_i = 1'b0;
    for (int a = 0; a < 3; a++) av[a] = s[a] / N_AVG;
  endtask

  function automatic bit in_win(input int d, input int lo, input int hi);
    return (d >= lo) && (d <= hi);
  endfunction

  // mode 0 random window, 1 min=max=delta, 2 min=delta+1, 3 max=delta-1
  task automatic run(input int b0, b1, b2, s0, s1, s2, input int mode, input bit poke);
    int av0 [3];
    int av1 [3];
    int lo [3];
    int hi [3];
    int w0 = wr_n;
    int d0 = done_n;
    bit [2:0] ep;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    wait_wr(w0 + 1);
    junk(SETTLE - 5);
    if (poke) begin
      @(negedge clk_i) start_i = 1'b1;
      @(negedge clk_i) start_i = 1'b0;
      idle(6);
    end else idle(8);
    win(b0, b1, b2, av0);
    wait_wr(w0 + 2);
    junk(SETTLE - 5);
    idle(8);
    win(b0 + s0, b1 + s1, b2 + s2, av1);
    for (int a = 0; a < 3; a++) begin
      exp_d[a] = av1[a] - av0[a];
      case (mode)
        1: begin lo[a] = exp_d[a];     hi[a] = exp_d[a];     end
        2: begin lo[a] = exp_d[a] + 1; hi[a] = exp_d[a] + 50; end
        3: begin lo[a] = exp_d[a] - 50; hi[a] = exp_d[a] - 1; end
        default: begin
          lo[a] = exp_d[a] - int'($urandom_range(0, 8)) + 3;
          hi[a] = exp_d[a] + int'($urandom_range(0, 8)) - 3;
        end
      endcase
      ep[a] = in_win(exp_d[a], lo[a], hi[a]);
    end
    lim_min_x_i = DW'(lo[0]); lim_max_x_i = DW'(hi[0]);
    lim_min_y_i = DW'(lo[1]); lim_max_y_i = DW'(hi[1]);
    lim_min_z_i = DW'(lo[2]); lim_max_z_i = DW'(hi[2]);
    junk(3);
    while (done_n == d0) @(negedge clk_i);
    // done_n incremented at the negedge where done_o is high: outputs valid now
    chk(wr_n - w0 == 3, "R11 write count", wr_n - w0, 3);
    chk(wr_a[w0] == 8'h31 && wr_d[w0] == 8'h0B, "R2 first write", int'(wr_d[w0]), 8'h0B);
    chk(wr_a[w0+1] == 8'h31 && wr_d[w0+1] == 8'h8B, "R5 self-test on write", int'(wr_d[w0+1]), 8'h8B);
    chk(wr_a[w0+2] == 8'h31 && wr_d[w0+2] == 8'h0B, "R6 self-test off write", int'(wr_d[w0+2]), 8'h0B);
    chk(int'(delta_x_o) == exp_d[0], "R7 R4 R3 delta x", int'(delta_x_o), exp_d[0]);
    chk(int'(delta_y_o) == exp_d[1], "R7 R4 R3 delta y", int'(delta_y_o), exp_d[1]);
    chk(int'(delta_z_o) == exp_d[2], "R7 R4 R3 delta z", int'(delta_z_o), exp_d[2]);
    chk(pass_o == ep, "R8 pass bits", int'(pass_o), int'(ep));
    idle(5);
    chk(!busy_o && int'(delta_y_o) == exp_d[1], "R9 results held", int'(delta_y_o), exp_d[1]);
  endtask

  // where 0: during first window, 1: during second settle wait
  task automatic run_abort(input int where);
    int w0 = wr_n;
    int d0 = done_n;
    int hx = int'(delta_x_o);
    int hp = int'(pass_o);
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    wait_wr(w0 + 1);
    if (where == 0) begin
      idle(SETTLE + 5);
      for (int i = 0; i < 20; i++) begin
        @(negedge clk_i) smp_valid_i = 1'b1;
      end
      @(negedge clk_i) begin smp_valid_i = 1'b0; abort_i = 1'b1; end
      @(negedge clk_i) abort_i = 1'b0;
    end else begin
      int av [3];
      idle(SETTLE + 5);
      win(10, 10, 10, av);
      wait_wr(w0 + 2);
      idle(5);
      @(negedge clk_i) abort_i = 1'b1;
      @(negedge clk_i) abort_i = 1'b0;
    end
    wait_wr(w0 + 2 + where);
    chk(wr_d[w0 + 1 + where] == 8'h0B && wr_a[w0 + 1 + where] == 8'h31,
        "R10 abort closes with self-test off", int'(wr_d[w0 + 1 + where]), 8'h0B);
    idle(2 * SETTLE + 20);
    chk(!busy_o, "R10 idle after abort", int'(busy_o), 0);
    chk(done_n == d0, "R10 no done after abort", done_n - d0, 0);
    chk(wr_n == w0 + 2 + where, "R10 no further writes", wr_n - w0, 2 + where);
    chk(int'(delta_x_o) == hx && int'(pass_o) == hp, "R10 results kept", int'(delta_x_o), hx);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1078));
    idle(3);
    @(negedge clk_i) rst_ni = 1'b1;
    idle(2);
    chk(!wr_req_o && !done_o && !busy_o, "R1 reset controls", int'({wr_req_o, done_o, busy_o}), 0);
    chk(pass_o == 3'b000 && delta_x_o == '0 && delta_y_o == '0 && delta_z_o == '0,
        "R1 reset results", int'(pass_o), 0);
    @(negedge clk_i) abort_i = 1'b1;
    @(negedge clk_i) abort_i = 1'b0;
    idle(5);
    chk(!busy_o && wr_n == 0, "R10 abort while idle ignored", wr_n, 0);

    run(-300, -1234, 256, 200, 140, 460, 1, 1'b0);
    run(-77, 55, -4000, -150, 333, 90, 2, 1'b0);
    run(1500, -900, 0, 220, -180, 600, 3, 1'b0);
    run(-1, -2, -3, 5, -7, 1, 0, 1'b1);
    run_abort(0);
    run_abort(1);
    for (int r = 0; r < 6; r++) begin
      int b [6];
      for (int a = 0; a < 6; a++) b[a] = int'($urandom_range(0, 6000)) - 3000;
      run(b[0], b[1], b[2], b[3] / 4, b[4] / 4, b[5] / 4, int'($urandom_range(0, 3)), r[0]);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule